// File: doc/BRIEF.md
# Offset-Count Memory Test Pattern Generator

This block produces the data and address stream used to fill and then read back an entire 4-bit-wide memory under test. The data comes from a triangular 8-bit count: it climbs from 0 to 255, falls from 254 back to 0, and then repeats with a period of 511 values. Each 8-bit value is split into two 4-bit words. The high nibble is written at an even address and the low nibble at the odd address that follows it.

The fill is divided into bursts of equal length. Each burst starts one position further along the triangular sequence than the burst before it. Because 511 shares no factor with any power of two, the stream never repeats on a power-of-two period. A memory whose address bits alias therefore returns data that does not match the expected stream. The same generator serves for the write pass and, restarted, as the source of expected data for the read pass.

The generator computes every value arithmetically from a sequence index that wraps modulo 511, so it needs no stored table. The consumer pulses `start`, holds `advance` high for each word it takes, and may pulse `restart` to replay the current burst from its first word.

Top module: `ocnt_pattern_gen`

## Requirements
- R1: After a synchronous reset, `running` and `done` are 0 and `word_addr` and `burst_idx` are 0.
- R2: One cycle after `start`, `running` is 1, `done` is 0, and `word_addr` and `burst_idx` are 0.
- R3: The 8-bit value for sequence index i (0 to 510) is i when i < 256 and 510 − i otherwise.
- R4: A word whose address bit 0 is 0 carries value bits 7:4, and a word whose address bit 0 is 1 carries value bits 3:0.
- R5: While running, each cycle with `advance` high moves the outputs to the next word one cycle later. A cycle with `advance` low leaves all outputs unchanged.
- R6: Within a burst, word w of burst b uses sequence index (b + w/2) mod 511, with integer division.
- R7: After the last word of a burst that is not the final burst, `burst_idx` increments and the word position returns to 0. The new burst therefore begins one sequence index later than the previous burst began.
- R8: `word_addr` equals `burst_idx` × BURST_WORDS + word position, with the burst index in the upper `BURST_W` bits and the word position in the lower `WORD_W` bits.
- R9: A `restart` while running returns to word 0 of the current burst one cycle later. `burst_idx` is kept and the data replays from that burst's first word.
- R10: One cycle after `advance` on the last word of the last burst, `done` is 1 and `running` is 0. Further `advance` pulses then change no output.
- R11: `start` has priority over `restart` and `advance`, and it begins a new fill from either the running state or the done state.
- R12: A reset asserted in the middle of a fill returns the block to the idle state of R1 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a fill from burst 0, word 0 |
| advance | input | 1 | Consume the current word and move to the next |
| restart | input | 1 | Replay the current burst from its first word |
| nibble | output | 4 | Data word for the current address |
| word_addr | output | BURST_W+WORD_W | Word address within the memory |
| burst_idx | output | BURST_W | Current burst number |
| running | output | 1 | A fill is in progress |
| done | output | 1 | The last word of the last burst has been consumed |

## Verification
The bench runs a full fill with small parameters. Each burst is long enough to cross the turning point of the count, the 510-to-0 wrap of the index and a burst boundary. A design with the mirrored half off by one, or with a wrap at 512 instead of 511, would show wrong nibbles there. A design that swapped the nibble halves, or stepped the index every word instead of every two words, would fail on the first few words of a burst. A generator that forgot the per-burst offset would replay burst 0 data in burst 1. Separate scenarios replay a burst mid-way through, hold `advance` low, advance past completion, and collide `start` with the other controls. These scenarios catch a restart that returns to the wrong offset, a done state that still moves, and a wrong control priority.

// File: rtl/ocnt_pattern_gen.sv
module ocnt_pattern_gen #(
  parameter int WORD_W  = 15,
  parameter int BURST_W = 12,
  parameter int VAL_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       advance,
  input  logic                       restart,
  output logic [VAL_W/2-1:0]         nibble,
  output logic [BURST_W+WORD_W-1:0]  word_addr,
  output logic [BURST_W-1:0]         burst_idx,
  output logic                       running,
  output logic                       done
);
  localparam int NIB_W  = VAL_W / 2;
  localparam int IDX_W  = VAL_W + 1;
  localparam int PERIOD = 2 ** IDX_W - 1;

  logic [WORD_W-1:0]  word_q;
  logic [BURST_W-1:0] burst_q;
  logic [IDX_W-1:0]   base_q, idx_q;
  logic               run_q, done_q;

  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] x);
    return (x == IDX_W'(PERIOD - 1)) ? '0 : x + 1'b1;
  endfunction

  wire last_word  = &word_q;
  wire last_burst = &burst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      word_q  <= '0;
      burst_q <= '0;
      base_q  <= '0;
      idx_q   <= '0;
    end else if (start) begin
      run_q   <= 1'b1;
      done_q  <= 1'b0;
      word_q  <= '0;
      burst_q <= '0;
      base_q  <= '0;
      idx_q   <= '0;
    end else if (run_q && restart) begin
      word_q <= '0;
      idx_q  <= base_q;
    end else if (run_q && advance) begin
      if (last_word) begin
        if (last_burst) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          burst_q <= burst_q + 1'b1;
          word_q  <= '0;
          base_q  <= wrap_inc(base_q);
          idx_q   <= wrap_inc(base_q);
        end
      end else begin
        word_q <= word_q + 1'b1;
        if (word_q[0]) idx_q <= wrap_inc(idx_q);
      end
    end
  end

  logic [IDX_W-1:0] mirror;
  logic [VAL_W-1:0] value;

  assign mirror    = IDX_W'(PERIOD - 1) - idx_q;
  assign value     = idx_q[VAL_W] ? mirror[VAL_W-1:0] : idx_q[VAL_W-1:0];
  assign nibble    = word_q[0] ? value[NIB_W-1:0] : value[VAL_W-1:NIB_W];
  assign word_addr = {burst_q, word_q};
  assign burst_idx = burst_q;
  assign running   = run_q;
  assign done      = done_q;
endmodule

// File: rtl/ocnt_pattern_gen_chk.sv
module ocnt_pattern_gen_chk #(
  parameter int WORD_W  = 15,
  parameter int BURST_W = 12,
  parameter int VAL_W   = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      start,
  input logic                      advance,
  input logic                      restart,
  input logic [VAL_W/2-1:0]        nibble,
  input logic [BURST_W+WORD_W-1:0] word_addr,
  input logic [BURST_W-1:0]        burst_idx,
  input logic                      running,
  input logic                      done
);
  localparam int ADDR_W = BURST_W + WORD_W;

  wire plain_step = running && advance && !start && !restart;

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !running);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (running && !advance && !start && !restart) |=>
      ($stable(word_addr) && $stable(nibble) && $stable(burst_idx)));

  p_addr_step_r8: assert property (@(posedge clk) disable iff (rst)
    (plain_step && !(&word_addr)) |=> (word_addr == ADDR_W'($past(word_addr) + 1'b1)));

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> (running && !done && word_addr == '0 && burst_idx == '0));

  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (running && restart && !start) |=>
      (word_addr[WORD_W-1:0] == '0 && burst_idx == $past(burst_idx)));

  p_done_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(word_addr) && $stable(nibble)));
endmodule

bind ocnt_pattern_gen ocnt_pattern_gen_chk #(
  .WORD_W(WORD_W), .BURST_W(BURST_W), .VAL_W(VAL_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .advance(advance), .restart(restart),
  .nibble(nibble), .word_addr(word_addr), .burst_idx(burst_idx),
  .running(running), .done(done)
);

// File: tb/ocnt_pattern_gen_bench.sv
module ocnt_pattern_gen_bench;
  localparam int WW = 10;
  localparam int BW = 2;
  localparam int AW = WW + BW;
  localparam int NW = 2 ** WW;
  localparam int NB = 2 ** BW;

  logic clk = 1'b0;
  logic rst = 1'b1, start = 1'b0, advance = 1'b0, restart = 1'b0;
  logic [3:0]    nibble;
  logic [AW-1:0] word_addr;
  logic [BW-1:0] burst_idx;
  logic          running, done;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ocnt_pattern_gen #(.WORD_W(WW), .BURST_W(BW), .VAL_W(8)) u_ocnt_pattern_gen (
    .clk(clk), .rst(rst), .start(start), .advance(advance), .restart(restart),
    .nibble(nibble), .word_addr(word_addr), .burst_idx(burst_idx),
    .running(running), .done(done)
  );

  function automatic int exp_nib(input int b, input int w);
    int i, v;
    i = (b + w / 2) % 511;
    v = (i < 256) ? i : 510 - i;
    return (w % 2 == 1) ? (v & 15) : (v >> 4);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_word(input string req, input int b, input int w);
    checks++;
    if (nibble != exp_nib(b, w) || word_addr != AW'(b * NW + w) || burst_idx != BW'(b)) begin
      errors++;
      $display("FAIL %s actual=nib %0d addr %0d burst %0d expected=nib %0d addr %0d burst %0d",
               req, nibble, word_addr, burst_idx, exp_nib(b, w), b * NW + w, b);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic step(input int n);
    advance = 1'b1;
    repeat (n) @(negedge clk);
    advance = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 running", running, 0);
    chk("R1 done", done, 0);
    chk("R1 addr", word_addr, 0);
    chk("R1 burst", burst_idx, 0);
  endtask

  task automatic t_full_fill();
    do_start();
    chk("R2 running", running, 1);
    chk("R2 addr", word_addr, 0);
    advance = 1'b1;
    for (int b = 0; b < NB; b++) begin
      for (int w = 0; w < NW; w++) begin
        chk_word("R3 R4 R6 R7 R8 stream", b, w);
        @(negedge clk);
      end
    end
    advance = 1'b0;
    chk("R10 done", done, 1);
    chk("R10 running", running, 0);
  endtask

  task automatic t_spot_values();
    do_start();
    step(512);
    chk("R3 mirrored value 254 hi", nibble, 15);
    step(1);
    chk("R3 mirrored value 254 lo", nibble, 14);
    step(1022 - 513);
    chk("R6 wrap to index 0", nibble, 0);
    step(2);
    chk("R7 next burst start index 1 hi", nibble, 0);
    step(1);
    chk("R4 low nibble of value 1", nibble, 1);
  endtask

  task automatic t_hold();
    logic [AW-1:0] a;
    logic [3:0] n;
    do_start();
    step(5);
    a = word_addr; n = nibble;
    repeat (3) @(negedge clk);
    chk("R5 hold addr", word_addr, a);
    chk("R5 hold nibble", nibble, n);
    chk("R5 one word per cycle", word_addr, 5);
  endtask

  task automatic t_restart();
    do_start();
    step(NW + 37);
    chk_word("R7 mid burst 1", 1, 37);
    restart = 1'b1; advance = 1'b1;
    @(negedge clk);
    restart = 1'b0; advance = 1'b0;
    chk_word("R9 replay burst 1 word 0", 1, 0);
    step(3);
    chk_word("R9 replay continues", 1, 3);
  endtask

  task automatic t_done_ignore();
    logic [AW-1:0] a;
    do_start();
    step(NW * NB);
    chk("R10 done reached", done, 1);
    a = word_addr;
    step(4);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk("R10 addr frozen", word_addr, a);
    chk("R10 done held", done, 1);
    do_start();
    chk("R11 start from done", done, 0);
    chk_word("R11 start from done word 0", 0, 0);
  endtask

  task automatic t_priority();
    do_start();
    step(NW + 9);
    @(negedge clk);
    start = 1'b1; restart = 1'b1; advance = 1'b1;
    @(negedge clk);
    start = 1'b0; restart = 1'b0; advance = 1'b0;
    chk_word("R11 start wins", 0, 0);
    chk("R11 running", running, 1);
  endtask

  task automatic t_reset_mid();
    do_start();
    step(NW + 100);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R12 running", running, 0);
    chk("R12 addr", word_addr, 0);
    chk("R12 burst", burst_idx, 0);
    chk("R12 done", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_full_fill();
    t_spot_values();
    t_hold();
    t_restart();
    t_done_ignore();
    t_priority();
    t_reset_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule